// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible face of a UART. A word-oriented bus presents a 12-bit byte address, a 32-bit write value and separate read and write strobes. The block decodes that 4 KB window into configuration registers (line control, control, baud divisors, low-power divisor, FIFO level select and DMA control), a flag word, a receive status word, an interrupt mask, raw and masked interrupt views, a write-one-to-clear interrupt register and an eight-byte identification table at the top of the window. It combines the raw interrupt bits with the mask to drive a single interrupt line.

The serial side is left to neighbouring blocks. Writing the data register hands the low byte to a transmit sink as a one-clock pulse, and the sink always accepts it. Reading the data register takes a word from a separate receive FIFO and pops it. The FIFO also reports empty, full, last-entry and arrival events. Read data is registered and appears one clock after the read strobe. There is no bus state machine: every access completes in the cycle its strobe is sampled.

Top module: `uart_reg_front`

## Requirements
- R1: After a synchronous reset, the FIFO level select register (offset 0x34) reads 0x12 and the control register (0x30) reads 0x300. The flag register (0x18) reads 0x90 while the FIFO reports empty and not full. Every other register reads 0, and irq and tx_valid are low.
- R2: A read returns its value on bus_rdata at the clock edge that samples bus_rd, and bus_rdata holds that value until the next read. Bits 1:0 of the address are ignored. A configuration register reads back the last written value masked to its width: low-power divisor 0x20 (8 bits), integer divisor 0x24 (16 bits), fractional divisor 0x28 (6 bits), line control 0x2C (8 bits), control 0x30 (16 bits), FIFO level select 0x34 (6 bits), DMA control 0x48 (3 bits).
- R3: A read at 0xFE0 + 4*k (k = 0..7) returns byte k of the table 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R4: A write to the data register (0x00) raises tx_valid for exactly one clock, starting at the edge that samples the write, with tx_byte equal to bus_wdata[7:0]. The same edge sets raw interrupt bit 5 (transmit).
- R5: A read of the data register returns {20'b0, rx_word}. It asserts rx_pop in the strobe cycle only when rx_empty is low, and it loads rx_word[11:8] into the receive status register (0x04, bits 3:0). Any write to 0x04 clears that register.
- R6: An rx_push pulse sets raw interrupt bit 4 (receive). A data read that pops while rx_last is high clears it, unless a push arrives in the same cycle.
- R7: A write to the interrupt clear register (0x44) clears every raw bit whose write-value bit is 1. A hardware set of the same bit in the same cycle wins.
- R8: The raw status (0x3C) reads the 11 raw bits. The mask (0x38) is 11 bits wide. The masked status (0x40) reads raw AND mask, and irq is high exactly when that AND is non-zero, from the edge that updated either of them.
- R9: The flag register reads bit 7 = 1 (transmit empty), bit 6 = rx_full, bit 5 = 0 (transmit never full), bit 4 = rx_empty, and all other bits 0. Writes to 0x18 change nothing.
- R10: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register and produces no transmit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write value |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read value |
| tx_valid | output | 1 | One-clock transmit byte pulse |
| tx_byte | output | 8 | Transmit byte |
| rx_word | input | 12 | Receive FIFO head: status bits 11:8, data 7:0 |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_last | input | 1 | Receive FIFO holds exactly one entry |
| rx_push | input | 1 | A received word entered the FIFO this cycle |
| rx_pop | output | 1 | Pop the receive FIFO head |
| irq | output | 1 | Combined interrupt |

## Verification
Register reads, tx_valid, tx_byte and the raw interrupt bits all change at the first clock edge after their strobe or event. irq follows combinationally from the registered raw and mask bits, so it is due at that same edge. rx_pop is combinational and is valid within the strobe cycle itself. The bench drives inputs on the falling edge. It samples registered results on the falling edge after the capturing rising edge, and it samples rx_pop one nanosecond after the strobe is driven. The configuration registers are swept with walking and constant patterns, and every identification entry and a spread of unmapped offsets are read.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int RAW_W  = 11;
    localparam int RXW_W  = 12;
    localparam int STS_W  = 4;
    localparam int NCFG   = 7;
    localparam int ID_N   = 8;
    localparam int ID_IW  = $clog2(ID_N);

    localparam logic [ADDR_W-1:0] OFF_DATA = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_RSTS = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_FLAG = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_MASK = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_RAW  = 12'h03C;
    localparam logic [ADDR_W-1:0] OFF_MSKD = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 12'h044;
    localparam logic [ADDR_W-1:0] ID_BASE  = 12'hFE0;

    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;

    function automatic logic [ADDR_W-1:0] cfg_off(input int i);
        case (i)
            0:       return 12'h020;
            1:       return 12'h024;
            2:       return 12'h028;
            3:       return 12'h02C;
            4:       return 12'h030;
            5:       return 12'h034;
            default: return 12'h048;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cfg_mask(input int i);
        case (i)
            0, 3:    return 32'h0000_00FF;
            1, 4:    return 32'h0000_FFFF;
            2, 5:    return 32'h0000_003F;
            default: return 32'h0000_0007;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cfg_rst(input int i);
        case (i)
            4:       return 32'h0000_0300;
            5:       return 32'h0000_0012;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] id_byte(input logic [ID_IW-1:0] k);
        case (k)
            3'd0:    return 8'h11;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    function automatic logic word_hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] off);
        return a[ADDR_W-1:2] == off[ADDR_W-1:2];
    endfunction
endpackage

// File: rtl/uart_cfg_bank.sv
module uart_cfg_bank
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    output logic              hit,
    output logic [DATA_W-1:0] rval
);
    logic [NCFG-1:0]              sel;
    logic [NCFG-1:0][DATA_W-1:0]  cfg_q;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        assign sel[g] = word_hit(addr, cfg_off(g));
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[g] <= cfg_rst(g);
            else if (wr && sel[g])
                cfg_q[g] <= wdata & cfg_mask(g);
        end
    end

    always_comb begin
        rval = '0;
        for (int i = 0; i < NCFG; i++)
            if (sel[i]) rval = cfg_q[i];
    end

    assign hit = |sel;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_set,
    input  logic             rx_set,
    input  logic             rx_clr,
    input  logic             clr_wr,
    input  logic [RAW_W-1:0] clr_val,
    input  logic             mask_wr,
    input  logic [RAW_W-1:0] mask_val,
    output logic [RAW_W-1:0] raw,
    output logic [RAW_W-1:0] mask,
    output logic             irq
);
    logic [RAW_W-1:0] raw_n;

    always_comb begin
        raw_n = raw;
        if (clr_wr) raw_n = raw_n & ~clr_val;
        if (rx_clr) raw_n[BIT_RX] = 1'b0;
        if (rx_set) raw_n[BIT_RX] = 1'b1;
        if (tx_set) raw_n[BIT_TX] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= raw_n;
            if (mask_wr) mask <= mask_val;
        end
    end

    assign irq = |(raw & mask);

    a_r7_clear_tx: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_val[BIT_TX] && !tx_set) |=> !raw[BIT_TX]);
    a_r6_push_sets_rx: assert property (@(posedge clk) disable iff (rst)
        rx_set |=> raw[BIT_RX]);
    a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask != '0));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
    import uart_fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic [11:0] rx_word,
    input  logic        rx_empty,
    input  logic        rx_full,
    input  logic        rx_last,
    input  logic        rx_push,
    output logic        rx_pop,
    output logic        irq
);
    logic              cfg_hit;
    logic [DATA_W-1:0] cfg_rval;
    logic [RAW_W-1:0]  raw, mask;
    logic [STS_W-1:0]  rsts_q;
    logic              hit_data, hit_rsts, hit_flag, hit_mask, hit_raw, hit_mskd, hit_clr, hit_id;
    logic              data_rd;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] flag_word;

    assign hit_data = word_hit(bus_addr, OFF_DATA);
    assign hit_rsts = word_hit(bus_addr, OFF_RSTS);
    assign hit_flag = word_hit(bus_addr, OFF_FLAG);
    assign hit_mask = word_hit(bus_addr, OFF_MASK);
    assign hit_raw  = word_hit(bus_addr, OFF_RAW);
    assign hit_mskd = word_hit(bus_addr, OFF_MSKD);
    assign hit_clr  = word_hit(bus_addr, OFF_CLR);
    assign hit_id   = bus_addr[ADDR_W-1:ID_IW+2] == ID_BASE[ADDR_W-1:ID_IW+2];

    assign data_rd = bus_rd && hit_data;
    assign rx_pop  = data_rd && !rx_empty;

    assign flag_word = {24'b0, 1'b1, rx_full, 1'b0, rx_empty, 4'b0};

    uart_cfg_bank u_cfg (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .wr    (bus_wr),
        .hit   (cfg_hit),
        .rval  (cfg_rval)
    );

    uart_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .tx_set   (bus_wr && hit_data),
        .rx_set   (rx_push),
        .rx_clr   (rx_pop && rx_last),
        .clr_wr   (bus_wr && hit_clr),
        .clr_val  (bus_wdata[RAW_W-1:0]),
        .mask_wr  (bus_wr && hit_mask),
        .mask_val (bus_wdata[RAW_W-1:0]),
        .raw      (raw),
        .mask     (mask),
        .irq      (irq)
    );

    always_comb begin
        rd_next = '0;
        if (hit_data)      rd_next = {{(DATA_W-RXW_W){1'b0}}, rx_word};
        else if (hit_rsts) rd_next = {{(DATA_W-STS_W){1'b0}}, rsts_q};
        else if (hit_flag) rd_next = flag_word;
        else if (hit_mask) rd_next = {{(DATA_W-RAW_W){1'b0}}, mask};
        else if (hit_raw)  rd_next = {{(DATA_W-RAW_W){1'b0}}, raw};
        else if (hit_mskd) rd_next = {{(DATA_W-RAW_W){1'b0}}, raw & mask};
        else if (hit_id)   rd_next = {24'b0, id_byte(bus_addr[ID_IW+1:2])};
        else if (cfg_hit)  rd_next = cfg_rval;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
            rsts_q    <= '0;
        end else begin
            if (bus_rd) bus_rdata <= rd_next;
            tx_valid <= bus_wr && hit_data;
            if (bus_wr && hit_data) tx_byte <= bus_wdata[7:0];
            if (bus_wr && hit_rsts)
                rsts_q <= '0;
            else if (data_rd)
                rsts_q <= rx_word[RXW_W-1:RXW_W-STS_W];
        end
    end

    a_r4_tx_sets_raw: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> raw[BIT_TX]);
    a_r2_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/uart_reg_front_tb.sv
module uart_reg_front_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic [11:0] rx_word = 0;
    logic        rx_empty = 1, rx_full = 0, rx_last = 0, rx_push = 0;
    logic        rx_pop, irq;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_reg_front u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic pop);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        #1 pop = rx_pop;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    logic [11:0] cfg_a [7] = '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h048};
    logic [31:0] cfg_m [7] = '{32'hFF, 32'hFFFF, 32'h3F, 32'hFF, 32'hFFFF, 32'h3F, 32'h7};
    logic [7:0]  id_t  [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [11:0] bad_a [8] = '{12'h008, 12'h00C, 12'h010, 12'h014, 12'h01C, 12'h04C, 12'h100, 12'hFDC};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic p; logic [31:0] pat;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(12'h034, d, p); chk("R1 ifls", d, 32'h12);
        rd(12'h030, d, p); chk("R1 ctrl", d, 32'h300);
        rd(12'h018, d, p); chk("R1 flags", d, 32'h90);
        rd(12'h024, d, p); chk("R1 ibrd", d, 0);
        rd(12'h03C, d, p); chk("R1 raw", d, 0);
        rd(12'h038, d, p); chk("R1 mask", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 0);
        // R2 configuration sweep
        for (int i = 0; i < 7; i++) begin
            for (int k = 0; k < 35; k++) begin
                pat = (k < 32) ? (32'h1 << k) : (k == 32 ? 32'hFFFF_FFFF : (k == 33 ? 32'hA5C3_5A3C : 32'h0));
                wr(cfg_a[i], pat);
                rd(cfg_a[i] | 12'h3, d, p); chk("R2 cfg readback", d, pat & cfg_m[i]);
            end
        end
        rd(12'h024, d, p);
        repeat (3) @(negedge clk);
        chk("R2 rdata holds", bus_rdata, 0);
        // R3 identification table
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(4 * k), d, p); chk("R3 id byte", d, {24'b0, id_t[k]});
        end
        // R4 transmit
        wr(12'h000, 32'h1A5);
        chk("R4 tx_valid high", {31'b0, tx_valid}, 1);
        chk("R4 tx_byte", {24'b0, tx_byte}, 32'hA5);
        @(negedge clk);
        chk("R4 tx_valid one clock", {31'b0, tx_valid}, 0);
        rd(12'h03C, d, p); chk("R4 raw tx", d, 32'h20);
        // R7 clear
        wr(12'h044, 32'h20);
        rd(12'h03C, d, p); chk("R7 cleared", d, 0);
        // R8 mask and irq
        wr(12'h038, 32'hFFFF_F020);
        chk("R8 irq low no raw", {31'b0, irq}, 0);
        rd(12'h038, d, p); chk("R8 mask width", d, 32'h020);
        wr(12'h000, 32'h42);
        chk("R8 irq high", {31'b0, irq}, 1);
        rd(12'h040, d, p); chk("R8 masked", d, 32'h20);
        wr(12'h038, 32'h0);
        chk("R8 irq masked off", {31'b0, irq}, 0);
        rd(12'h040, d, p); chk("R8 masked zero", d, 0);
        rd(12'h03C, d, p); chk("R8 raw kept", d, 32'h20);
        // R6 receive interrupt
        @(negedge clk); rx_push = 1; rx_empty = 0; rx_last = 1; rx_word = 12'h2C3;
        @(negedge clk); rx_push = 0;
        rd(12'h03C, d, p); chk("R6 raw rx set", d, 32'h30);
        // R5 data read pops
        rd(12'h000, d, p);
        chk("R5 data word", d, 32'h2C3);
        chk("R5 pop", {31'b0, p}, 1);
        rd(12'h03C, d, p); chk("R6 rx cleared by last pop", d, 32'h20);
        rd(12'h004, d, p); chk("R5 status latched", d, 32'h2);
        wr(12'h004, 32'h0);
        rd(12'h004, d, p); chk("R5 status cleared", d, 0);
        rx_empty = 1; rx_last = 0; rx_word = 12'h07E;
        rd(12'h000, d, p);
        chk("R5 empty no pop", {31'b0, p}, 0);
        chk("R5 empty data", d, 32'h07E);
        // R7 set beats clear
        @(negedge clk); rx_push = 1; bus_addr = 12'h044; bus_wdata = 32'h30; bus_wr = 1;
        @(negedge clk); rx_push = 0; bus_wr = 0;
        rd(12'h03C, d, p); chk("R7 set wins", d, 32'h10);
        wr(12'h044, 32'h7FF);
        rd(12'h03C, d, p); chk("R7 clear all", d, 0);
        // R9 flags
        rx_empty = 0; rx_full = 1;
        rd(12'h018, d, p); chk("R9 flags full", d, 32'hC0);
        wr(12'h018, 32'hFFFF_FFFF);
        rd(12'h018, d, p); chk("R9 flag write ignored", d, 32'hC0);
        rx_empty = 1; rx_full = 0;
        rd(12'h018, d, p); chk("R9 flags empty", d, 32'h90);
        // R10 unmapped
        wr(12'h030, 32'h0);
        for (int k = 0; k < 8; k++) begin
            wr(bad_a[k], 32'hFFFF_FFFF);
            chk("R10 no tx pulse", {31'b0, tx_valid}, 0);
            rd(bad_a[k], d, p); chk("R10 unmapped read", d, 0);
        end
        for (int i = 0; i < 7; i++) begin
            rd(cfg_a[i], d, p); chk("R10 cfg untouched", d, 0);
        end
        rd(12'h03C, d, p); chk("R10 raw untouched", d, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule